// File: doc/BRIEF.md
# Instruction Fetch Line Buffer

This block sits between instruction memory and the decoder. It holds a small, fully associative set of 256-bit instruction lines, each tagged with address bits [31:5]. One line is the *current* line and supplies one 32-bit instruction per cycle to the decoder through a valid/ready handshake. A second line, the *next* line, is filled in the background with the line that follows the current one. When the current line has been used up, the next line takes its place and a new background fill starts. This works like a double buffer laid over a few extra resident lines.

Lines are fetched whole over a request/response memory port. A request carries a line tag. Memory answers with one full line and echoes the tag, and several requests may be outstanding at once. Each line is in one of three states: empty, filling or ready. The decoder is held off while the current line is not ready. Taken jumps are resolved against the resident lines. A jump inside the current line continues without a switch. A jump to another resident line makes that line current. A jump that misses claims a line and fetches it. A jump that leaves the current/next pair drops an unfinished fill of the old next line.

Top module: `ifb_line_buffer`

## Requirements
- R1: While reset is held, and until the first clock edge after it, `instr_valid` is 0 and a request for the line holding `RESET_PC` is presented, with `mem_req_tag = RESET_PC[31:5]`.
- R2: When `instr_valid` is 1, `instr_pc` is a word address and `instr` is bits `[32*w +: 32]` of the line whose tag is `instr_pc[31:5]`, where `w = instr_pc[4:2]`.
- R3: `instr_valid` stays 0 while the current line is not ready. A current line that is empty is requested before any other line.
- R4: An accepted instruction (`instr_valid & dec_ready`, no taken jump) advances `instr_pc` by 4. Crossing a line boundary continues in the following line, and the line after that (tag + 1) is requested.
- R5: A taken jump whose target tag equals the current line's tag sets `instr_pc` to the target in the next cycle, keeps `instr_valid` high and issues no memory request.
- R6: A taken jump to another resident line makes it current without fetching it again. `instr_valid` is high in the next cycle, and the line with tag target + 1 is requested.
- R7: A taken jump to a line that is not resident drops `instr_valid` in the next cycle and presents a request for the target tag. The stream resumes at the target once that line arrives.
- R8: A jump with `jmp_valid = 1` and `jmp_taken = 0` has no effect. `instr_pc` and the memory requests behave as if no jump were given.
- R9: A taken jump overrides an accepted handshake in the same cycle. The next `instr_pc` is the target, not the target + 4 and not the old pc + 4.
- R10: The current and next lines are never chosen for replacement and are always distinct slots. If a taken jump leaves the pair while the old next line is not ready, that line is emptied and its later response is discarded.
- R11: A response fills only a line that is in the filling state with the same tag. Any other response changes no line, so a later jump to its tag still misses and requests that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_ready | input | 1 | Decoder accepts the presented instruction |
| instr_valid | output | 1 | An instruction is presented |
| instr | output | 32 | Presented instruction word |
| instr_pc | output | 32 | Byte address of the presented instruction |
| jmp_valid | input | 1 | A jump is resolved this cycle |
| jmp_taken | input | 1 | The resolved jump is taken |
| jmp_target | input | 32 | Byte address of the jump target |
| mem_req_valid | output | 1 | Line request is presented |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_tag | output | 27 | Tag (address bits 31:5) of the requested line |
| mem_rsp_valid | input | 1 | Memory returns a line |
| mem_rsp_tag | input | 27 | Tag of the returned line |
| mem_rsp_line | input | 256 | Returned line, instruction 0 in bits 31:0 |

## Verification
The bench builds the buffer with `LINES = 4`. This is the smallest size that leaves two replaceable slots beside the current/next pair. With it, a random jump walk over ten distinct lines forces constant replacement, and any eviction of the current or next line shows up as a wrong instruction word. A fixed memory latency of four cycles leaves a window in which a second jump can land before the first jump's next-line fill returns. The directed cases use that window to reach the abandoned-fill and stray-response cases.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
    localparam int ADDR_W  = 32;
    localparam int INSTR_W = 32;
    localparam int WORDS   = 8;
    localparam int LINE_W  = INSTR_W * WORDS;
    localparam int OFF_W   = $clog2(LINE_W / 8);
    localparam int TAG_W   = ADDR_W - OFF_W;

    typedef enum logic [1:0] {
        LN_EMPTY = 2'd0,
        LN_FILL  = 2'd1,
        LN_READY = 2'd2
    } ln_state_e;
endpackage

// File: rtl/ifb_tag_cam.sv
module ifb_tag_cam #(
    parameter int N  = 8,
    parameter int TW = 27
) (
    input  logic [N-1:0][TW-1:0]   tags,
    input  logic [N-1:0]           live,
    input  logic [TW-1:0]          key,
    output logic                   hit,
    output logic [$clog2(N)-1:0]   idx
);
    localparam int IW = $clog2(N);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = live[g] && (tags[g] == key);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ifb_victim.sv
module ifb_victim #(
    parameter int N = 8
) (
    input  logic [$clog2(N)-1:0] start,
    input  logic [N-1:0]         excl,
    output logic [$clog2(N)-1:0] pick
);
    localparam int IW = $clog2(N);

    always_comb begin
        pick = start;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(start) + k) % N;
            if (!excl[j]) begin
                pick = IW'(j);
            end
        end
    end
endmodule

// File: rtl/ifb_line_buffer.sv
module ifb_line_buffer
    import ifb_pkg::*;
#(
    parameter int          LINES    = 8,
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_ready,
    output logic                instr_valid,
    output logic [INSTR_W-1:0]  instr,
    output logic [ADDR_W-1:0]   instr_pc,
    input  logic                jmp_valid,
    input  logic                jmp_taken,
    input  logic [ADDR_W-1:0]   jmp_target,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [TAG_W-1:0]    mem_req_tag,
    input  logic                mem_rsp_valid,
    input  logic [TAG_W-1:0]    mem_rsp_tag,
    input  logic [LINE_W-1:0]   mem_rsp_line
);
    localparam int IDX_W = $clog2(LINES);
    localparam int WSEL  = $clog2(WORDS);

    typedef struct packed {
        ln_state_e [LINES-1:0]              st;
        logic [LINES-1:0][TAG_W-1:0]        tag;
        logic [LINES-1:0][LINE_W-1:0]       data;
        logic [IDX_W-1:0]                   cur;
        logic [IDX_W-1:0]                   nxt;
        logic                               need_nxt;
        logic [IDX_W-1:0]                   rr;
        logic [ADDR_W-1:0]                  pc;
    } fb_state_t;

    fb_state_t q, d;

    logic [WSEL-1:0]   word;
    logic [TAG_W-1:0]  cur_tag;
    logic [TAG_W-1:0]  seq_tag;
    logic              req_cur, req_nxt;
    logic [IDX_W-1:0]  req_idx;
    logic [LINES-1:0]  live, excl;
    logic              j_hit, n_hit;
    logic [IDX_W-1:0]  j_idx, n_idx, vic, vic_after;
    logic              jump_go;
    logic              take;

    // monitor taps for the bound checker
    logic [IDX_W-1:0]  cur_idx_mon, nxt_idx_mon;
    logic              need_nxt_mon;
    assign cur_idx_mon  = q.cur;
    assign nxt_idx_mon  = q.nxt;
    assign need_nxt_mon = q.need_nxt;

    assign word    = q.pc[OFF_W-1:2];
    assign cur_tag = q.tag[q.cur];
    assign seq_tag = cur_tag + TAG_W'(1);
    assign jump_go = jmp_valid && jmp_taken;

    assign instr_valid = (q.st[q.cur] == LN_READY) &&
                         !(q.need_nxt && (word == WSEL'(WORDS - 1)));
    assign instr       = q.data[q.cur][{word, 5'b0} +: INSTR_W];
    assign instr_pc    = q.pc;

    assign req_cur       = (q.st[q.cur] == LN_EMPTY);
    assign req_nxt       = !q.need_nxt && (q.st[q.nxt] == LN_EMPTY);
    assign mem_req_valid = req_cur || req_nxt;
    assign req_idx       = req_cur ? q.cur : q.nxt;
    assign mem_req_tag   = q.tag[req_idx];

    assign take = instr_valid && dec_ready && !jump_go;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            live[i] = (q.st[i] != LN_EMPTY) || (IDX_W'(i) == q.cur) ||
                      (!q.need_nxt && (IDX_W'(i) == q.nxt));
            excl[i] = (IDX_W'(i) == q.cur) ||
                      (!q.need_nxt && (IDX_W'(i) == q.nxt));
        end
    end

    ifb_tag_cam #(.N(LINES), .TW(TAG_W)) u_jcam (
        .tags (q.tag), .live (live), .key (jmp_target[ADDR_W-1:OFF_W]),
        .hit  (j_hit), .idx  (j_idx)
    );

    ifb_tag_cam #(.N(LINES), .TW(TAG_W)) u_ncam (
        .tags (q.tag), .live (live), .key (seq_tag),
        .hit  (n_hit), .idx  (n_idx)
    );

    ifb_victim #(.N(LINES)) u_vic (
        .start (q.rr), .excl (excl), .pick (vic)
    );

    assign vic_after = (vic == IDX_W'(LINES - 1)) ? '0 : vic + IDX_W'(1);

    always_comb begin
        logic [IDX_W-1:0] new_cur;
        d       = q;
        new_cur = q.cur;

        // returned line: only a filling line with the same tag accepts it
        if (mem_rsp_valid) begin
            for (int i = 0; i < LINES; i++) begin
                if (q.st[i] == LN_FILL && q.tag[i] == mem_rsp_tag) begin
                    d.st[i]   = LN_READY;
                    d.data[i] = mem_rsp_line;
                end
            end
        end

        // request handed to memory
        if (mem_req_valid && mem_req_ready) begin
            d.st[req_idx] = LN_FILL;
        end

        if (jump_go) begin
            d.pc = jmp_target & 32'hFFFF_FFFC;
            if (jmp_target[ADDR_W-1:OFF_W] != cur_tag) begin
                if (j_hit) begin
                    new_cur = j_idx;
                end else begin
                    new_cur       = vic;
                    d.tag[vic]    = jmp_target[ADDR_W-1:OFF_W];
                    d.st[vic]     = LN_EMPTY;
                    d.rr          = vic_after;
                end
                if (!q.need_nxt && new_cur != q.nxt && d.st[q.nxt] != LN_READY) begin
                    d.st[q.nxt] = LN_EMPTY;
                end
                d.cur      = new_cur;
                d.need_nxt = 1'b1;
            end
        end else if (q.need_nxt) begin
            if (n_hit) begin
                d.nxt = n_idx;
            end else begin
                d.nxt      = vic;
                d.tag[vic] = seq_tag;
                d.st[vic]  = LN_EMPTY;
                d.rr       = vic_after;
            end
            d.need_nxt = 1'b0;
            if (take) begin
                d.pc = q.pc + 32'd4;
            end
        end else if (take) begin
            d.pc = q.pc + 32'd4;
            if (word == WSEL'(WORDS - 1)) begin
                d.cur      = q.nxt;
                d.need_nxt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.tag[0]   <= RESET_PC[ADDR_W-1:OFF_W];
            q.need_nxt <= 1'b1;
            q.rr       <= IDX_W'(1);
            q.pc       <= RESET_PC & 32'hFFFF_FFFC;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ifb_line_buffer_chk.sv
module ifb_line_buffer_chk #(
    parameter int LINES = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     dec_ready,
    input logic                     instr_valid,
    input logic [31:0]              instr_pc,
    input logic                     jmp_valid,
    input logic                     jmp_taken,
    input logic [31:0]              jmp_target,
    input logic [$clog2(LINES)-1:0] cur_idx,
    input logic [$clog2(LINES)-1:0] nxt_idx,
    input logic                     need_nxt
);
    // R4: an accepted word moves the pc one word forward
    a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dec_ready && !(jmp_valid && jmp_taken))
        |=> (instr_pc == $past(instr_pc) + 32'd4));

    // R8: without a taken jump or an accepted word the pc holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(jmp_valid && jmp_taken) && !(instr_valid && dec_ready))
        |=> $stable(instr_pc));

    // R5 / R9: a taken jump lands exactly on the aligned target
    a_r5_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid && jmp_taken)
        |=> (instr_pc == ($past(jmp_target) & 32'hFFFF_FFFC)));

    // R10: the protected pair never shares a slot
    a_r10_pair_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        !need_nxt |-> (cur_idx != nxt_idx));

    // R2: presented addresses are word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> (instr_pc[1:0] == 2'b00));
endmodule

bind ifb_line_buffer ifb_line_buffer_chk #(.LINES(LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_ready   (dec_ready),
    .instr_valid (instr_valid),
    .instr_pc    (instr_pc),
    .jmp_valid   (jmp_valid),
    .jmp_taken   (jmp_taken),
    .jmp_target  (jmp_target),
    .cur_idx     (cur_idx_mon),
    .nxt_idx     (nxt_idx_mon),
    .need_nxt    (need_nxt_mon)
);

// File: tb/ifb_line_buffer_bench.sv
module ifb_line_buffer_bench;
    localparam int          LINES = 4;
    localparam logic [31:0] RPC   = 32'h0000_1000;
    localparam int          LAT   = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dec_ready = 1'b0;
    logic         instr_valid;
    logic [31:0]  instr;
    logic [31:0]  instr_pc;
    logic         jmp_valid = 1'b0;
    logic         jmp_taken = 1'b0;
    logic [31:0]  jmp_target = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [26:0]  mem_req_tag;
    logic         mem_rsp_valid = 1'b0;
    logic [26:0]  mem_rsp_tag = '0;
    logic [255:0] mem_rsp_line = '0;

    always #10 clk = ~clk;

    ifb_line_buffer #(.LINES(LINES), .RESET_PC(RPC)) u_ifb_line_buffer (
        .clk, .rst_n, .dec_ready, .instr_valid, .instr, .instr_pc,
        .jmp_valid, .jmp_taken, .jmp_target,
        .mem_req_valid, .mem_req_ready, .mem_req_tag,
        .mem_rsp_valid, .mem_rsp_tag, .mem_rsp_line
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    function automatic logic [31:0] word_at(logic [31:0] a);
        logic [31:0] w;
        w = a & 32'hFFFF_FFFC;
        return w ^ 32'h3C5A_96E1 ^ {w[15:0], w[31:16]};
    endfunction

    function automatic logic [255:0] line_of(logic [26:0] t);
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = word_at({t, i[2:0], 2'b00});
        return l;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: acts at the falling edge, seen by the block at the rising edge
    bit          rdy_force = 1'b1;
    bit          inj_pending = 1'b0;
    logic [26:0] inj_tag = '0;
    int          cyc = 0;
    int          req_cnt = 0;
    logic [26:0] req_log [0:4095];
    logic [26:0] pq_tag [0:63];
    int          pq_due [0:63];
    int          pq_h = 0, pq_t = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            mem_req_ready = rdy_force ? 1'b1 : ($urandom % 4 != 0);
            if (mem_req_valid && mem_req_ready) begin
                req_log[req_cnt % 4096] = mem_req_tag;
                req_cnt++;
                pq_tag[pq_t % 64] = mem_req_tag;
                pq_due[pq_t % 64] = cyc + LAT;
                pq_t++;
            end
            mem_rsp_valid = 1'b0;
            if (inj_pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_tag   = inj_tag;
                mem_rsp_line  = line_of(inj_tag);
                inj_pending   = 1'b0;
            end else if (pq_h != pq_t && pq_due[pq_h % 64] <= cyc) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_tag   = pq_tag[pq_h % 64];
                mem_rsp_line  = line_of(pq_tag[pq_h % 64]);
                pq_h++;
            end
        end
    end

    function automatic bit requested(int from, logic [26:0] t);
        for (int i = from; i < req_cnt; i++) if (req_log[i % 4096] == t) return 1'b1;
        return 1'b0;
    endfunction

    logic [31:0] exp_pc = RPC;
    int consumed = 0;

    task automatic step_sample();
        @(negedge clk);
        #2;
        if (instr_valid) begin
            chk(instr_pc == exp_pc, "R4 pc", instr_pc, exp_pc);
            chk(instr == word_at(exp_pc), "R2 word", instr, word_at(exp_pc));
        end
    endtask

    task automatic drive(bit rdy, bit jv, bit jt, logic [31:0] tgt);
        dec_ready  = rdy;
        jmp_valid  = jv;
        jmp_taken  = jt;
        jmp_target = tgt;
        if (jv && jt) exp_pc = tgt & 32'hFFFF_FFFC;
        else if (instr_valid && rdy) begin
            exp_pc = exp_pc + 32'd4;
            consumed++;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            step_sample();
            drive(1'b0, 1'b0, 1'b0, '0);
        end
    endtask

    initial begin
        int cnt0;
        int seen;
        logic [26:0] ct, ft, at, bt, st;
        logic [31:0] pc0;
        cnt0 = int'($urandom(32'd20240));

        for (int i = 0; i < 4; i++) @(negedge clk);
        #2;
        // R1: reset state
        chk(instr_valid == 1'b0, "R1 valid", instr_valid, 0);
        chk(mem_req_valid == 1'b1, "R1 req", mem_req_valid, 1);
        chk(mem_req_tag == RPC[31:5], "R1 tag", mem_req_tag, RPC[31:5]);
        rst_n = 1'b1;

        // R3: first cycle after reset has no line yet
        step_sample();
        chk(instr_valid == 1'b0, "R3 stall", instr_valid, 0);
        drive(1'b1, 1'b0, 1'b0, '0);

        // R4: sequential streaming across lines
        for (int i = 0; i < 60; i++) begin
            step_sample();
            drive(1'b1, 1'b0, 1'b0, '0);
        end
        chk(consumed >= 30, "R4 progress", consumed, 30);
        chk(requested(0, RPC[31:5] + 27'd1), "R4 prefetch+1", 0, 1);
        chk(requested(0, RPC[31:5] + 27'd2), "R4 prefetch+2", 0, 1);

        // R5: jump inside current line
        idle(20);
        step_sample();
        ct = exp_pc[31:5];
        cnt0 = req_cnt;
        drive(1'b0, 1'b1, 1'b1, {ct, 5'd12});
        step_sample();
        chk(instr_valid == 1'b1, "R5 no stall", instr_valid, 1);
        drive(1'b0, 1'b0, 1'b0, '0);
        idle(5);
        chk(req_cnt == cnt0, "R5 no request", req_cnt, cnt0);

        // R8: not-taken jump
        step_sample();
        pc0 = instr_pc;
        cnt0 = req_cnt;
        drive(1'b0, 1'b1, 1'b0, {ct + 27'd50, 5'd0});
        step_sample();
        chk(instr_pc == pc0, "R8 pc held", instr_pc, pc0);
        drive(1'b1, 1'b1, 1'b0, {ct + 27'd50, 5'd0});
        idle(4);
        chk(req_cnt == cnt0, "R8 no request", req_cnt, cnt0);

        // R6: jump to resident next line
        idle(20);
        step_sample();
        ct = exp_pc[31:5];
        if (exp_pc[4:2] == 3'd7) ct = ct + 27'd0;
        cnt0 = req_cnt;
        drive(1'b0, 1'b1, 1'b1, {ct + 27'd1, 5'd8});
        step_sample();
        chk(instr_valid == 1'b1, "R6 resident", instr_valid, 1);
        drive(1'b0, 1'b0, 1'b0, '0);
        idle(8);
        chk(!requested(cnt0, ct + 27'd1), "R6 no refetch", 1, 0);
        chk(requested(cnt0, ct + 27'd2), "R6 successor", 0, 1);

        // R9: taken jump beats the handshake
        idle(10);
        step_sample();
        ct = exp_pc[31:5];
        drive(1'b1, 1'b1, 1'b1, {ct, 5'd8});
        step_sample();
        chk(instr_pc == {ct, 5'd8}, "R9 target", instr_pc, {ct, 5'd8});
        drive(1'b0, 1'b0, 1'b0, '0);

        // R7: jump to a line that is not resident
        idle(10);
        step_sample();
        ft = exp_pc[31:5] + 27'd40;
        drive(1'b0, 1'b1, 1'b1, {ft, 5'd20});
        step_sample();
        chk(instr_valid == 1'b0, "R7 stall", instr_valid, 0);
        chk(mem_req_valid && mem_req_tag == ft, "R7 request", mem_req_tag, ft);
        drive(1'b0, 1'b0, 1'b0, '0);
        seen = 0;
        for (int i = 0; i < 30 && seen == 0; i++) begin
            step_sample();
            if (instr_valid) seen = 1;
            drive(1'b0, 1'b0, 1'b0, '0);
        end
        chk(seen == 1, "R7 resumes", seen, 1);

        // R10: abandoned next-line fill
        idle(10);
        step_sample();
        at = exp_pc[31:5] + 27'd80;
        bt = exp_pc[31:5] + 27'd120;
        cnt0 = req_cnt;
        drive(1'b0, 1'b1, 1'b1, {at, 5'd0});
        idle(2);
        step_sample();
        chk(requested(cnt0, at + 27'd1), "R10 fill launched", 0, 1);
        drive(1'b0, 1'b1, 1'b1, {bt, 5'd0});
        idle(20);
        step_sample();
        cnt0 = req_cnt;
        drive(1'b0, 1'b1, 1'b1, {at + 27'd1, 5'd4});
        idle(12);
        chk(requested(cnt0, at + 27'd1), "R10 refetch", 0, 1);
        step_sample();
        chk(instr_valid == 1'b1, "R10 resumes", instr_valid, 1);
        drive(1'b0, 1'b0, 1'b0, '0);

        // R11: stray response fills nothing
        idle(10);
        step_sample();
        st = exp_pc[31:5] + 27'd200;
        inj_tag = st;
        inj_pending = 1'b1;
        drive(1'b0, 1'b0, 1'b0, '0);
        idle(3);
        step_sample();
        cnt0 = req_cnt;
        drive(1'b0, 1'b1, 1'b1, {st, 5'd4});
        step_sample();
        chk(instr_valid == 1'b0, "R11 not resident", instr_valid, 0);
        drive(1'b0, 1'b0, 1'b0, '0);
        idle(12);
        chk(requested(cnt0, st), "R11 requested", 0, 1);

        // random walk: replacement pressure and back-pressure
        rdy_force = 1'b0;
        consumed = 0;
        for (int i = 0; i < 3000; i++) begin
            bit jv, jt;
            logic [26:0] rt;
            step_sample();
            jv = ($urandom % 12 == 0);
            jt = $urandom % 2;
            rt = RPC[31:5] + 27'd300 + 27'($urandom % 10);
            drive($urandom % 4 != 0, jv, jt, {rt, 3'($urandom % 8), 2'b00});
        end
        chk(consumed > 500, "R3 random progress", consumed, 500);

        $display("  test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule